// File: doc/BRIEF.md
# Transmit FIFO Drain and Interrupt Generator

This block sits between a small transmit sample FIFO and a stereo codec sample port. Software writes audio samples one at a time into the FIFO through a simple register write port. When transmission is enabled and at least one audio slot is selected, the block sends the stored samples to the codec as left/right pairs. A burst of pairs begins only once the FIFO is at least half full. The burst ends when the FIFO runs short or when the codec is not ready to take a pair. The codec is modelled as a valid/ready port that receives one pair per accepted offer.

After every push and every drained pair, the block keeps four status flags up to date: full, half-empty, empty and a sticky underrun flag. From these it forms three raw interrupt causes. It masks them with a software-written enable mask and drives a single interrupt line. Writing a dedicated clear register removes the underrun condition. Writing the main control register with its enable bit low returns every register and the FIFO to the reset state.

Whether to start a burst is decided in the cycle after any register write or any codec data request, so both software activity and the codec's demand can start a transfer. Register addresses are: 0 transmit control, 1 interrupt mask, 2 interrupt clear, 3 main control, 4 sample data.

Top module: `aud_tx_drain`

## Requirements
- R1: After reset, fifo_level is 0, flag_empty and flag_half are 1, flag_full and flag_underrun are 0, snd_valid is 0, all_ints is 7'b0000110 and irq is 0.
- R2: A write to address 4 stores wr_data[SW-1:0] as one sample while fifo_level is below DEPTH. When fifo_level equals DEPTH, the write is dropped and the level is unchanged. flag_full becomes 1 when the level reaches DEPTH.
- R3: A burst starts only if, in the cycle after a register write or a codec_req pulse, all of these hold: transmit control bit 0 (enable) is 1, bit 1 or bit 2 (slot selects) is 1, and fifo_level is at least DEPTH/2. Otherwise no pair is offered.
- R4: Each offered pair takes the oldest sample as snd_left and the next-oldest sample as snd_right. A burst offers at most (level at start)/2 pairs, and each accepted pair lowers fifo_level by 2.
- R5: An offer made while snd_ready is 0 ends the burst after that single cycle. The refused pair stays in the FIFO and is the first pair of the next burst.
- R6: A push clears flag_empty, and clears flag_half once the level reaches DEPTH/2. A drained pair clears flag_full, sets flag_half when the level falls to DEPTH/2 or below, and sets both flag_empty and flag_underrun when the level reaches 0.
- R7: all_ints carries the raw causes zero-extended to 7 bits: bit 0 is the underrun flag, bit 1 is the half-empty flag, and bit 2 is set when the FIFO is empty and no burst is in progress.
- R8: irq is 1 exactly when the raw causes ANDed with the mask are nonzero. The mask is written at address 1, bits [2:0], and is 0 after reset.
- R9: flag_underrun stays set until a write to address 2 with bit 0 set. A write to address 2 with bit 0 clear leaves it unchanged.
- R10: A write to address 3 with bit 0 clear returns the FIFO, the flags, the transmit control and the mask to the reset state. A write with bit 0 set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | SW | Register write data |
| codec_req | input | 1 | Codec data request pulse |
| snd_ready | input | 1 | Codec accepts the offered pair |
| snd_valid | output | 1 | Pair offered to codec |
| snd_left | output | SW | Left sample of the pair |
| snd_right | output | SW | Right sample of the pair |
| fifo_level | output | $clog2(DEPTH+1) | Samples stored |
| flag_full | output | 1 | FIFO full flag |
| flag_half | output | 1 | Half-empty flag |
| flag_empty | output | 1 | Empty flag |
| flag_underrun | output | 1 | Sticky underrun flag |
| all_ints | output | 7 | Raw interrupt causes, zero-extended |
| irq | output | 1 | Masked interrupt line |

## Verification
Some properties are checked on every cycle. The level never exceeds the depth. The full flag implies a full level, and the empty flag implies a zero level. A pair is never offered with fewer than two samples stored. A burst only begins after a cycle in which the enable, slot and threshold conditions held. A refused offer ends the burst. Underrun only rises together with empty, and a soft clear leaves the reset state behind it. Other behaviours depend on stimulus, so only the directed scenarios can show them: the order of left and right samples, dropped pushes at full, the hysteresis of the half-empty flag, resumption after back-pressure, the effect of the mask on the interrupt line, and the stickiness of underrun.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_IMASK = 3'd1,
      RA_ICLR  = 3'd2,
      RA_MAIN  = 3'd3,
      RA_DATA  = 3'd4
   } reg_addr_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_SLA_BIT  = 1;
   localparam int CTRL_SLB_BIT  = 2;
   localparam int NUM_CAUSES    = 3;
   localparam int ALLINT_W      = 7;
endpackage

// File: rtl/aud_tx_store.sv
module aud_tx_store #(
   parameter int DEPTH = 8,
   parameter int SW    = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [SW-1:0] din,
   input  logic          pop,
   output logic [SW-1:0] left,
   output logic [SW-1:0] right
);
   localparam int PW = $clog2(DEPTH);

   logic [SW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + PW'(1);
         if (pop)  rp <= rp + PW'(2);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wp] <= din;
   end

   assign left  = mem[rp];
   assign right = mem[rp + PW'(1)];
endmodule

// File: rtl/aud_tx_level.sv
module aud_tx_level #(
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push_req,
   input  logic          pop,
   input  logic          clr_ur,
   output logic          push_ok,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          half,
   output logic          empty,
   output logic          ur
);
   localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
   localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

   logic [LW-1:0] lvl_p, lvl_n;
   logic          f_n, h_n, e_n, u_n;

   assign push_ok = push_req && (level != FULL_L);

   always_comb begin
      lvl_p = level + LW'(push_ok);
      lvl_n = pop ? (lvl_p - LW'(2)) : lvl_p;
      f_n = full;
      h_n = half;
      e_n = empty;
      u_n = ur;
      if (clr_ur) u_n = 1'b0;
      if (push_ok) begin
         e_n = 1'b0;
         if (lvl_p >= HALF_L) h_n = 1'b0;
         if (lvl_p >= FULL_L) f_n = 1'b1;
      end
      if (pop) begin
         f_n = 1'b0;
         if (lvl_n <= HALF_L) h_n = 1'b1;
         if (lvl_n == '0) begin
            e_n = 1'b1;
            u_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
         full  <= 1'b0;
         half  <= 1'b1;
         empty <= 1'b1;
         ur    <= 1'b0;
      end else if (clr) begin
         level <= '0;
         full  <= 1'b0;
         half  <= 1'b1;
         empty <= 1'b1;
         ur    <= 1'b0;
      end else begin
         level <= lvl_n;
         full  <= f_n;
         half  <= h_n;
         empty <= e_n;
         ur    <= u_n;
      end
   end
endmodule

// File: rtl/aud_tx_drain_ctl.sv
module aud_tx_drain_ctl #(
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          trig,
   input  logic          en,
   input  logic          slots_any,
   input  logic [LW-1:0] level,
   input  logic          ready,
   output logic          busy,
   output logic          pop
);
   localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

   logic          pend;
   logic [LW-1:0] cnt;
   logic          start;

   assign start = pend && en && slots_any && (level >= HALF_L) && !busy;
   assign pop   = busy && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         busy <= 1'b0;
         cnt  <= '0;
      end else if (clr) begin
         pend <= 1'b0;
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         pend <= trig || (pend && busy);
         if (start) begin
            busy <= 1'b1;
            cnt  <= level >> 1;
         end else if (busy) begin
            if (!ready || cnt == LW'(1)) busy <= 1'b0;
            if (ready) cnt <= cnt - LW'(1);
         end
      end
   end
endmodule

// File: rtl/aud_tx_irq.sv
module aud_tx_irq
   import aud_tx_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  mask_we,
   input  logic [NUM_CAUSES-1:0] mask_d,
   input  logic                  ur,
   input  logic                  half,
   input  logic                  empty,
   input  logic                  busy,
   output logic [ALLINT_W-1:0]   all_ints,
   output logic                  irq
);
   logic [NUM_CAUSES-1:0] mask_q;
   logic [NUM_CAUSES-1:0] raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (clr)     mask_q <= '0;
      else if (mask_we) mask_q <= mask_d;
   end

   assign raw      = {empty && !busy, half, ur};
   assign all_ints = {{(ALLINT_W - NUM_CAUSES){1'b0}}, raw};
   assign irq      = |(raw & mask_q);
endmodule

// File: rtl/aud_tx_drain.sv
module aud_tx_drain
   import aud_tx_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int SW    = 20,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_addr,
   input  logic [SW-1:0]       wr_data,
   input  logic                codec_req,
   input  logic                snd_ready,
   output logic                snd_valid,
   output logic [SW-1:0]       snd_left,
   output logic [SW-1:0]       snd_right,
   output logic [LW-1:0]       fifo_level,
   output logic                flag_full,
   output logic                flag_half,
   output logic                flag_empty,
   output logic                flag_underrun,
   output logic [ALLINT_W-1:0] all_ints,
   output logic                irq
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (SW < NUM_CAUSES || SW > 32) begin : g_bad_sw
      $error("SW must lie between 3 and 32");
   end

   logic       wr_ctrl, wr_mask, wr_iclr, wr_main, push_req;
   logic       soft_clr, clr_ur, push_ok, pop, busy;
   logic       tx_en, slots_any;
   logic [2:0] ctrl_q;

   assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
   assign wr_mask  = wr_en && (wr_addr == RA_IMASK);
   assign wr_iclr  = wr_en && (wr_addr == RA_ICLR);
   assign wr_main  = wr_en && (wr_addr == RA_MAIN);
   assign push_req = wr_en && (wr_addr == RA_DATA);
   assign soft_clr = wr_main && !wr_data[0];
   assign clr_ur   = wr_iclr && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (soft_clr) ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wr_data[2:0];
   end

   assign tx_en     = ctrl_q[CTRL_EN_BIT];
   assign slots_any = ctrl_q[CTRL_SLA_BIT] || ctrl_q[CTRL_SLB_BIT];

   aud_tx_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push(push_ok), .din(wr_data), .pop(pop),
      .left(snd_left), .right(snd_right)
   );

   aud_tx_level #(.DEPTH(DEPTH), .LW(LW)) u_level (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push_req(push_req), .pop(pop), .clr_ur(clr_ur),
      .push_ok(push_ok), .level(fifo_level), .full(flag_full),
      .half(flag_half), .empty(flag_empty), .ur(flag_underrun)
   );

   aud_tx_drain_ctl #(.DEPTH(DEPTH), .LW(LW)) u_drain (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .trig(wr_en || codec_req), .en(tx_en), .slots_any(slots_any),
      .level(fifo_level), .ready(snd_ready), .busy(busy), .pop(pop)
   );

   aud_tx_irq u_irq (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .mask_we(wr_mask), .mask_d(wr_data[NUM_CAUSES-1:0]),
      .ur(flag_underrun), .half(flag_half), .empty(flag_empty),
      .busy(busy), .all_ints(all_ints), .irq(irq)
   );

   assign snd_valid = busy;
endmodule

// File: rtl/aud_tx_drain_chk.sv
module aud_tx_drain_chk #(
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [LW-1:0] level,
   input logic          full,
   input logic          half,
   input logic          empty,
   input logic          ur,
   input logic          valid,
   input logic          ready,
   input logic          en,
   input logic          slots_any,
   input logic          soft_clr
);
   localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
   localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_L);
   a_r2_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> level == FULL_L);
   a_r6_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> level == '0);
   a_r4_pair_avail: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> level >= LW'(2));
   a_r3_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(en && slots_any && level >= HALF_L));
   a_r5_stop_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> !valid);
   a_r6_underrun_with_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ur) |-> empty);
   a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (level == '0 && empty && half && !full && !ur && !valid));
endmodule

bind aud_tx_drain aud_tx_drain_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .level(fifo_level), .full(flag_full),
   .half(flag_half), .empty(flag_empty), .ur(flag_underrun),
   .valid(snd_valid), .ready(snd_ready), .en(tx_en),
   .slots_any(slots_any), .soft_clr(soft_clr)
);

// File: tb/tb_aud_tx_drain.sv
module tb_aud_tx_drain;
   localparam int DEPTH = 8;
   localparam int SW    = 20;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [SW-1:0] wr_data = '0;
   logic          codec_req = 1'b0;
   logic          snd_ready = 1'b1;
   logic          snd_valid;
   logic [SW-1:0] snd_left, snd_right;
   logic [LW-1:0] fifo_level;
   logic          flag_full, flag_half, flag_empty, flag_underrun;
   logic [6:0]    all_ints;
   logic          irq;

   int checks = 0;
   int errors = 0;
   int offers = 0;
   int npairs = 0;
   logic [SW-1:0] pl [32];
   logic [SW-1:0] pr [32];

   always #2 clk = ~clk;

   aud_tx_drain #(.DEPTH(DEPTH), .SW(SW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .codec_req(codec_req), .snd_ready(snd_ready),
      .snd_valid(snd_valid), .snd_left(snd_left), .snd_right(snd_right),
      .fifo_level(fifo_level), .flag_full(flag_full), .flag_half(flag_half),
      .flag_empty(flag_empty), .flag_underrun(flag_underrun),
      .all_ints(all_ints), .irq(irq)
   );

   always @(negedge clk) begin
      if (rst_n && snd_valid) begin
         offers++;
         if (snd_ready && npairs < 32) begin
            pl[npairs] = snd_left;
            pr[npairs] = snd_right;
            npairs++;
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [SW-1:0] d);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic pulse_req();
      codec_req = 1'b1;
      tick(1);
      codec_req = 1'b0;
   endtask

   task automatic clear_log();
      offers = 0;
      npairs = 0;
   endtask

   task automatic t_reset();
      chk("R1 level", 32'(fifo_level), 0);
      chk("R1 flags", {28'd0, flag_full, flag_half, flag_empty, flag_underrun}, 32'b0110);
      chk("R1 valid", 32'(snd_valid), 0);
      chk("R1 all_ints", 32'(all_ints), 32'h6);
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_fill_and_drain();
      clear_log();
      for (int i = 0; i < 3; i++) wr(3'd4, SW'(20'h100 + i));
      chk("R6 half kept below threshold", 32'(flag_half), 1);
      chk("R6 empty cleared by push", 32'(flag_empty), 0);
      wr(3'd4, SW'(20'h103));
      chk("R6 half cleared at threshold", 32'(flag_half), 0);
      for (int i = 4; i < 8; i++) wr(3'd4, SW'(20'h100 + i));
      chk("R2 full at depth", 32'(flag_full), 1);
      wr(3'd4, SW'(20'hBAD));
      chk("R2 push dropped when full", 32'(fifo_level), 8);
      chk("R3 no offer while disabled", 32'(offers), 0);
      wr(3'd0, SW'(3));
      tick(10);
      chk("R4 pair count", 32'(npairs), 4);
      for (int i = 0; i < 4; i++) begin
         chk("R4 left sample", 32'(pl[i]), 32'h100 + 32'(2 * i));
         chk("R4 right sample", 32'(pr[i]), 32'h101 + 32'(2 * i));
      end
      chk("R4 level after drain", 32'(fifo_level), 0);
      chk("R6 flags after drain", {28'd0, flag_full, flag_half, flag_empty, flag_underrun}, 32'b0111);
      chk("R7 all_ints all causes", 32'(all_ints), 32'h7);
   endtask

   task automatic t_gate();
      clear_log();
      wr(3'd0, SW'(1));
      for (int i = 0; i < 4; i++) wr(3'd4, SW'(20'h200 + i));
      tick(4);
      chk("R3 no slot selected", 32'(offers), 0);
      wr(3'd0, SW'(6));
      pulse_req();
      tick(4);
      chk("R3 enable clear", 32'(offers), 0);
      chk("R3 level held", 32'(fifo_level), 4);
      wr(3'd0, SW'(5));
      tick(6);
      chk("R3 drain with slot b", 32'(npairs), 2);
      chk("R4 gate pair left", 32'(pl[1]), 32'h202);
      chk("R4 gate pair right", 32'(pr[1]), 32'h203);
      chk("R4 gate level", 32'(fifo_level), 0);
   endtask

   task automatic t_below_threshold();
      clear_log();
      for (int i = 0; i < 3; i++) wr(3'd4, SW'(20'h250 + i));
      pulse_req();
      tick(4);
      chk("R3 below threshold no offer", 32'(offers), 0);
      wr(3'd4, SW'(20'h253));
      tick(6);
      chk("R3 threshold reached drains", 32'(fifo_level), 0);
   endtask

   task automatic t_backpressure();
      clear_log();
      snd_ready = 1'b0;
      for (int i = 0; i < 4; i++) wr(3'd4, SW'(20'h300 + i));
      tick(4);
      chk("R5 single refused offer", 32'(offers), 1);
      chk("R5 refused pair kept", 32'(fifo_level), 4);
      snd_ready = 1'b1;
      pulse_req();
      tick(6);
      chk("R5 resumed pairs", 32'(npairs), 2);
      chk("R5 refused pair first left", 32'(pl[0]), 32'h300);
      chk("R5 refused pair first right", 32'(pr[0]), 32'h301);
      chk("R5 level after resume", 32'(fifo_level), 0);
   endtask

   task automatic t_irq_mask();
      wr(3'd1, SW'(0));
      chk("R8 mask zero", 32'(irq), 0);
      wr(3'd1, SW'(1));
      chk("R8 underrun enabled", 32'(irq), 1);
      wr(3'd2, SW'(0));
      chk("R9 clear bit low ignored", 32'(flag_underrun), 1);
      wr(3'd2, SW'(1));
      chk("R9 underrun cleared", 32'(flag_underrun), 0);
      chk("R8 irq drops after clear", 32'(irq), 0);
      chk("R7 all_ints without underrun", 32'(all_ints), 32'h6);
      wr(3'd1, SW'(2));
      chk("R8 half cause enabled", 32'(irq), 1);
   endtask

   task automatic t_soft_clear();
      wr(3'd0, SW'(0));
      for (int i = 0; i < 5; i++) wr(3'd4, SW'(20'h400 + i));
      chk("R8 half cause gone", 32'(irq), 0);
      wr(3'd3, SW'(1));
      chk("R10 enable set no effect", 32'(fifo_level), 5);
      wr(3'd3, SW'(0));
      chk("R10 level cleared", 32'(fifo_level), 0);
      chk("R10 flags reset", {28'd0, flag_full, flag_half, flag_empty, flag_underrun}, 32'b0110);
      chk("R10 all_ints reset", 32'(all_ints), 32'h6);
      chk("R10 mask cleared", 32'(irq), 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_fill_and_drain();
      t_gate();
      t_below_threshold();
      t_backpressure();
      t_irq_mask();
      t_soft_clear();
      finish_run();
   end
endmodule